// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block is the combinational front of a small processor's fetch stage. It receives the current program counter and a six-byte slice of instruction memory that begins at that address, together with a flag from the memory that marks the fetch address as bad. Within the same cycle it returns the decoded fields of the instruction.

The opcode nibble alone sets the instruction length: 1, 2, 5 or 6 bytes. It also sets whether a register-specifier byte is present and where a 32-bit little-endian constant sits. The decoder splits the first byte into its two nibbles and pulls out the two register IDs. It assembles the constant, adds the length to the PC to give the sequential next address, and reports a three-bit status.

Downstream stages use the register IDs to read the register file, the constant as an immediate, displacement or target, and the status to decide whether the machine keeps running.

Top module: `vld_top`

## Requirements
- R1: `opCode` is bits 7:4 of window byte 0 (window bits 7:0) and `funCode` is bits 3:0 of that byte.
- R2: `instLen` depends only on `opCode`. It is 1 for codes 0x0, 0x1 and 0x9. It is 2 for codes 0x2, 0x6, 0xA and 0xB. It is 5 for codes 0x7 and 0x8. It is 6 for codes 0x3, 0x4 and 0x5. It is 1 for codes 0xC to 0xF.
- R3: `nextPc` equals `pc + instLen` modulo 2^32.
- R4: For codes 0x2 through 0x6, 0xA and 0xB, `regA` is the high nibble and `regB` the low nibble of window byte 1. For every other code both are 0xF, the value meaning "no register".
- R5: `constVal` is the little-endian word in window bytes 1..4 for codes 0x7 and 0x8, and in window bytes 2..5 for codes 0x3, 0x4 and 0x5. It is zero for every other code.
- R6: Status is 4 (invalid) when any of these holds: the opcode is above 0xB; code 0x6 has a function above 3; code 0x2 or 0x7 has a function above 6; any other defined code has a nonzero function.
- R7: Without a memory error or invalid encoding, status is 2 (halted) for opcode 0x0 and 1 (normal) otherwise.
- R8: `memErr` high forces status 3 (bad address), over both invalid and halted.
- R9: A window of all-zero bytes decodes as halt: length 1, `nextPc = pc + 1`, status 2, register IDs 0xF, constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the instruction being fetched |
| fetchWin | input | 48 | Memory bytes at pc..pc+5, byte k at bits 8k+7:8k |
| memErr | input | 1 | Fetch address is invalid |
| opCode | output | 4 | Instruction code nibble |
| funCode | output | 4 | Function code nibble |
| regA | output | 4 | First register ID, 0xF if absent |
| regB | output | 4 | Second register ID, 0xF if absent |
| constVal | output | 32 | Immediate, displacement or target, 0 if absent |
| instLen | output | 3 | Instruction length in bytes |
| nextPc | output | 32 | Sequential next address |
| status | output | 3 | 1 normal, 2 halted, 3 bad address, 4 invalid |

## Verification
The block holds no state, so a wrong internal strobe appears at the outputs in the same cycle as the window that provokes it. A wrong length class shows up as a wrong `nextPc` and usually also as a shifted constant or misplaced register IDs. A wrong validity decision shows up only in `status`. Every opcode is therefore paired with both legal and illegal function codes, and combined with the memory-error flag, to separate the three status priorities.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  localparam logic [NIB_W-1:0] OP_HALT  = 4'h0;
  localparam logic [NIB_W-1:0] OP_NOP   = 4'h1;
  localparam logic [NIB_W-1:0] OP_CMOV  = 4'h2;
  localparam logic [NIB_W-1:0] OP_IMM   = 4'h3;
  localparam logic [NIB_W-1:0] OP_STORE = 4'h4;
  localparam logic [NIB_W-1:0] OP_LOAD  = 4'h5;
  localparam logic [NIB_W-1:0] OP_ALU   = 4'h6;
  localparam logic [NIB_W-1:0] OP_JUMP  = 4'h7;
  localparam logic [NIB_W-1:0] OP_CALL  = 4'h8;
  localparam logic [NIB_W-1:0] OP_RET   = 4'h9;
  localparam logic [NIB_W-1:0] OP_PUSH  = 4'hA;
  localparam logic [NIB_W-1:0] OP_POP   = 4'hB;

  localparam logic [NIB_W-1:0] NO_REG   = 4'hF;
  localparam logic [NIB_W-1:0] ALU_FUN_MAX  = 4'd3;
  localparam logic [NIB_W-1:0] COND_FUN_MAX = 4'd6;

  typedef enum logic [2:0] {
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } stat_e;

  typedef enum logic [1:0] {
    LC_ONE   = 2'd0,
    LC_REG   = 2'd1,
    LC_DEST  = 2'd2,
    LC_FULL  = 2'd3
  } len_class_e;

  typedef struct packed {
    logic       hasRegs;
    logic       constAt1;
    logic       constAt2;
    len_class_e lenClass;
  } dec_strobe_t;
endpackage

// File: rtl/vld_ctrl.sv
module vld_ctrl
  import vld_pkg::*;
(
  input  logic [NIB_W-1:0] opCode,
  input  logic [NIB_W-1:0] funCode,
  input  logic             memErr,
  output dec_strobe_t      strobe,
  output stat_e            statOut
);
  logic badEnc;

  always_comb begin
    strobe = '{hasRegs: 1'b0, constAt1: 1'b0, constAt2: 1'b0, lenClass: LC_ONE};
    badEnc = 1'b0;
    case (opCode)
      OP_HALT, OP_NOP, OP_RET: begin
        badEnc = (funCode != '0);
      end
      OP_CMOV: begin
        strobe.hasRegs  = 1'b1;
        strobe.lenClass = LC_REG;
        badEnc = (funCode > COND_FUN_MAX);
      end
      OP_ALU: begin
        strobe.hasRegs  = 1'b1;
        strobe.lenClass = LC_REG;
        badEnc = (funCode > ALU_FUN_MAX);
      end
      OP_PUSH, OP_POP: begin
        strobe.hasRegs  = 1'b1;
        strobe.lenClass = LC_REG;
        badEnc = (funCode != '0);
      end
      OP_IMM, OP_STORE, OP_LOAD: begin
        strobe.hasRegs  = 1'b1;
        strobe.constAt2 = 1'b1;
        strobe.lenClass = LC_FULL;
        badEnc = (funCode != '0);
      end
      OP_JUMP: begin
        strobe.constAt1 = 1'b1;
        strobe.lenClass = LC_DEST;
        badEnc = (funCode > COND_FUN_MAX);
      end
      OP_CALL: begin
        strobe.constAt1 = 1'b1;
        strobe.lenClass = LC_DEST;
        badEnc = (funCode != '0);
      end
      default: begin
        badEnc = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (memErr)               statOut = ST_ADR;
    else if (badEnc)          statOut = ST_INS;
    else if (opCode == OP_HALT) statOut = ST_HLT;
    else                      statOut = ST_AOK;
  end
endmodule

// File: rtl/vld_dpath.sv
module vld_dpath
  import vld_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int WIN_BYTES = WORD_BYTES + 2,
  localparam int WIN_W     = WIN_BYTES * BYTE_W,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int LEN_W     = $clog2(WIN_BYTES + 1)
)(
  input  logic [ADDR_W-1:0] pc,
  input  logic [WIN_W-1:0]  fetchWin,
  input  dec_strobe_t       strobe,
  output logic [NIB_W-1:0]  opCode,
  output logic [NIB_W-1:0]  funCode,
  output logic [NIB_W-1:0]  regA,
  output logic [NIB_W-1:0]  regB,
  output logic [WORD_W-1:0] constVal,
  output logic [LEN_W-1:0]  instLen,
  output logic [ADDR_W-1:0] nextPc
);
  logic [WORD_W-1:0] wordAt1;
  logic [WORD_W-1:0] wordAt2;

  assign opCode  = fetchWin[BYTE_W-1:NIB_W];
  assign funCode = fetchWin[NIB_W-1:0];

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_word
    assign wordAt1[k*BYTE_W +: BYTE_W] = fetchWin[(k+1)*BYTE_W +: BYTE_W];
    assign wordAt2[k*BYTE_W +: BYTE_W] = fetchWin[(k+2)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (strobe.hasRegs) begin
      regA = fetchWin[2*BYTE_W-1 -: NIB_W];
      regB = fetchWin[BYTE_W+NIB_W-1 -: NIB_W];
    end else begin
      regA = NO_REG;
      regB = NO_REG;
    end
  end

  always_comb begin
    if (strobe.constAt1)      constVal = wordAt1;
    else if (strobe.constAt2) constVal = wordAt2;
    else                      constVal = '0;
  end

  always_comb begin
    case (strobe.lenClass)
      LC_REG:  instLen = LEN_W'(2);
      LC_DEST: instLen = LEN_W'(WORD_BYTES + 1);
      LC_FULL: instLen = LEN_W'(WORD_BYTES + 2);
      default: instLen = LEN_W'(1);
    endcase
  end

  assign nextPc = pc + ADDR_W'(instLen);
endmodule

// File: rtl/vld_top.sv
module vld_top
  import vld_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int WIN_W     = (WORD_BYTES + 2) * 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int LEN_W     = $clog2(WORD_BYTES + 3)
)(
  input  logic [ADDR_W-1:0] pc,
  input  logic [WIN_W-1:0]  fetchWin,
  input  logic              memErr,
  output logic [3:0]        opCode,
  output logic [3:0]        funCode,
  output logic [3:0]        regA,
  output logic [3:0]        regB,
  output logic [WORD_W-1:0] constVal,
  output logic [LEN_W-1:0]  instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic [2:0]        status
);
  dec_strobe_t strobe;
  stat_e       statInt;

  vld_ctrl ctrl_i (
    .opCode  (opCode),
    .funCode (funCode),
    .memErr  (memErr),
    .strobe  (strobe),
    .statOut (statInt)
  );

  vld_dpath #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) dpath_i (
    .pc       (pc),
    .fetchWin (fetchWin),
    .strobe   (strobe),
    .opCode   (opCode),
    .funCode  (funCode),
    .regA     (regA),
    .regB     (regB),
    .constVal (constVal),
    .instLen  (instLen),
    .nextPc   (nextPc)
  );

  assign status = statInt;
endmodule

// File: rtl/vld_chk.sv
module vld_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 3
)(
  input logic [ADDR_W-1:0] pc,
  input logic              memErr,
  input logic [3:0]        opCode,
  input logic [3:0]        funCode,
  input logic [3:0]        regA,
  input logic [3:0]        regB,
  input logic [WORD_W-1:0] constVal,
  input logic [LEN_W-1:0]  instLen,
  input logic [ADDR_W-1:0] nextPc,
  input logic [2:0]        status
);
  always_comb begin
    // R8
    adr_prio_chk: assert (!memErr || status == 3'd3);
    // R3
    next_pc_chk: assert (nextPc == pc + ADDR_W'(instLen));
    // R2
    len_legal_chk: assert (instLen == 1 || instLen == 2 || instLen == LEN_W'(WORD_W/8 + 1) || instLen == LEN_W'(WORD_W/8 + 2));
    // R4
    no_reg_chk: assert (!(instLen == 1 || instLen == LEN_W'(WORD_W/8 + 1)) || (regA == 4'hF && regB == 4'hF));
    // R5
    no_const_chk: assert (instLen > 2 || constVal == '0);
    // R7
    halt_stat_chk: assert (memErr || opCode != 4'h0 || funCode != 4'h0 || status == 3'd2);
  end
endmodule

bind vld_top vld_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) chk_i (
  .pc       (pc),
  .memErr   (memErr),
  .opCode   (opCode),
  .funCode  (funCode),
  .regA     (regA),
  .regB     (regB),
  .constVal (constVal),
  .instLen  (instLen),
  .nextPc   (nextPc),
  .status   (status)
);

// File: tb/vld_top_tb_top.sv
`timescale 1ns/1ps
module vld_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] pc;
  logic [47:0] fetchWin;
  logic        memErr;
  logic [3:0]  opCode, funCode, regA, regB;
  logic [31:0] constVal, nextPc;
  logic [2:0]  instLen, status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vld_top dut_i (
    .pc(pc), .fetchWin(fetchWin), .memErr(memErr),
    .opCode(opCode), .funCode(funCode), .regA(regA), .regB(regB),
    .constVal(constVal), .instLen(instLen), .nextPc(nextPc), .status(status)
  );

  function automatic bit [31:0] byteAt(input logic [47:0] w, input int k);
    return {24'd0, w[k*8 +: 8]};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic [47:0] w, input logic e);
    int op, fn, len;
    bit bad, regs;
    logic [31:0] c;
    logic [31:0] expA, expB;
    int st;
    @(negedge clk);
    pc = p; fetchWin = w; memErr = e;
    op = w[7:4]; fn = w[3:0];
    regs = 0; c = 0;
    case (op)
      0, 1, 9: begin len = 1; bad = (fn != 0); end
      2:       begin len = 2; regs = 1; bad = (fn > 6); end
      6:       begin len = 2; regs = 1; bad = (fn > 3); end
      10, 11:  begin len = 2; regs = 1; bad = (fn != 0); end
      7, 8:    begin len = 5; bad = (op == 7) ? (fn > 6) : (fn != 0);
                 c = byteAt(w,1) | (byteAt(w,2) << 8) | (byteAt(w,3) << 16) | (byteAt(w,4) << 24); end
      3, 4, 5: begin len = 6; regs = 1; bad = (fn != 0);
                 c = byteAt(w,2) | (byteAt(w,3) << 8) | (byteAt(w,4) << 16) | (byteAt(w,5) << 24); end
      default: begin len = 1; bad = 1; end
    endcase
    expA = regs ? {28'd0, w[15:12]} : 32'hF;
    expB = regs ? {28'd0, w[11:8]}  : 32'hF;
    st = e ? 3 : bad ? 4 : (op == 0) ? 2 : 1;
    @(posedge clk); #1;
    check("R1", "opCode", {28'd0, opCode}, op);
    check("R1", "funCode", {28'd0, funCode}, fn);
    check("R2", "instLen", {29'd0, instLen}, len);
    check("R3", "nextPc", nextPc, p + len);
    check("R4", "regA", {28'd0, regA}, expA);
    check("R4", "regB", {28'd0, regB}, expB);
    check("R5", "constVal", constVal, c);
    if (e)        check("R8", "status", {29'd0, status}, st);
    else if (bad) check("R6", "status", {29'd0, status}, st);
    else          check("R7", "status", {29'd0, status}, st);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pc = 0; fetchWin = 0; memErr = 0;
    // R9: all-zero window is halt
    apply(32'h100, 48'h0, 0);
    // R5: load-immediate 30 f2 cd ab 00 00
    apply(32'h200, 48'h0000_abcd_f230, 0);
    // R3: wrap of nextPc at the top of the address space
    apply(32'hFFFF_FFFE, 48'h0000_abcd_f230, 0);
    // R5: call with destination 0x12345678
    apply(32'h40, 48'h00_12_34_56_78_80, 0);
    // R6 / R8 priority on an invalid code
    apply(32'h44, 48'h0000_0000_00C0, 0);
    apply(32'h44, 48'h0000_0000_00C0, 1);
    apply(32'h48, 48'h0, 1);
    // every opcode with every function code
    for (int op = 0; op < 16; op++)
      for (int fn = 0; fn < 16; fn++)
        apply(32'h1000 + op*16 + fn,
              {8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h3C, 4'(op), 4'(fn)}, 0);
    // random windows and memory errors
    for (int i = 0; i < 600; i++)
      apply($urandom, {$urandom, 16'($urandom)}, ($urandom % 8) == 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule